// File: doc/BRIEF.md
# HDLC Receive Line Status Monitor

This block watches the decoded receive bit stream of a serial HDLC channel and reports three live line conditions in one 8-bit read-only status word. A bit-valid strobe marks the cycles that carry a new decoded bit. Only those cycles move any internal state. The decoded bit comes from an upstream clock-recovery stage, not from the raw line.

The flag indicator searches the stream one bit at a time for the pattern 0x7E. Once it finds the pattern, the indicator stops sliding and holds for eight bit times. It then judges the next aligned block of eight bits as a whole. If that block is another 0x7E, the indicator holds for another eight bits. If not, the indicator drops and the bit-by-bit search starts again. The idle indicator rises after a run of fifteen ones and falls on the first zero. The carrier indicator is the clock-recovery stage's carrier level, passed straight through.

Reading the status word is a plain combinational view and has no side effects.

Top module: `hdlc_rx_status_mon`

## Requirements
- R1: While reset is asserted (rstN low), and just after it is released, the flag indicator (status bit 2) and the idle indicator (status bit 0) read 0. The bit history is all zeros.
- R2: While the flag indicator is clear, it sets on the clock edge that accepts a valid bit which makes the eight most recent valid bits equal 0x7E (01111110 in arrival order). This happens at any bit alignment.
- R3: After the flag indicator sets, it stays set through the next seven valid bits, whatever their value.
- R4: On the eighth valid bit after a set or a re-arm, the flag indicator stays set if those eight bits form 0x7E. The count of eight then restarts.
- R5: On that eighth valid bit, the flag indicator clears if the block is not 0x7E. The search then resumes bit by bit, so the very next valid bits may set the indicator again at a new alignment.
- R6: The idle indicator sets on the valid bit that completes fifteen consecutive valid ones. It clears on the edge that accepts a single valid zero.
- R7: The ones-run count saturates, so the idle indicator stays set through arbitrarily long runs of ones.
- R8: Status bit 1 equals the carrierIn input combinationally, in every cycle.
- R9: Status bits 7 to 3 always read 0.
- R10: Cycles with bitValid low change neither indicator, and the rxBit value on those cycles never enters the bit history.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| bitValid | input | 1 | High on cycles that carry a new decoded bit |
| rxBit | input | 1 | Decoded receive bit |
| carrierIn | input | 1 | Carrier-sense level from the clock-recovery stage |
| statusWord | output | 8 | {5'b0, flag, carrier, idle} |

## Verification
A bad hold counter shows at the ports as the flag indicator falling or staying on at the wrong valid bit. It becomes visible within eight valid bits of the first flag, on the aligned re-check. A history register that takes bits on non-valid cycles, or a run counter that wraps, shows as a wrong flag or idle value within one window or one long run of ones. The stimulus therefore mixes aligned and misaligned flags, long one-runs and gaps in bitValid, and compares every status bit after every cycle.

// File: rtl/hdlc_mon_pkg.sv
package hdlc_mon_pkg;
  typedef struct packed {
    logic shiftEn;   // accept one decoded bit into history and run counter
    logic holdLoad;  // (re)start the hold window
    logic holdDec;   // count one bit of the hold window
  } monCtl_t;
endpackage

// File: rtl/hdlc_mon_dp.sv
module hdlc_mon_dp
  import hdlc_mon_pkg::*;
#(
  parameter int WIN_W    = 8,
  parameter logic [WIN_W-1:0] FLAG_PAT = 8'h7E,
  parameter int IDLE_RUN = 15,
  parameter int HOLD_LEN = 8
) (
  input  logic    clk,
  input  logic    rstN,
  input  monCtl_t ctl,
  input  logic    rxBit,
  output logic    winMatch,
  output logic    holdLast,
  output logic    idleNow
);
  localparam int RUN_W  = $clog2(IDLE_RUN + 1);
  localparam int HOLD_W = $clog2(HOLD_LEN + 1);

  logic [WIN_W-1:0]  history;
  logic [WIN_W-1:0]  nextWin;
  logic [RUN_W-1:0]  onesRun;
  logic [HOLD_W-1:0] holdCnt;

  // window as it will be once the current bit is accepted
  assign nextWin  = {history[WIN_W-2:0], rxBit};
  assign winMatch = (nextWin == FLAG_PAT);
  assign holdLast = (holdCnt == HOLD_W'(1));
  assign idleNow  = (onesRun == RUN_W'(IDLE_RUN));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      history <= '0;
    end else if (ctl.shiftEn) begin
      history <= nextWin;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      onesRun <= '0;
    end else if (ctl.shiftEn) begin
      if (!rxBit) begin
        onesRun <= '0;
      end else if (onesRun != RUN_W'(IDLE_RUN)) begin
        onesRun <= onesRun + RUN_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      holdCnt <= '0;
    end else if (ctl.holdLoad) begin
      holdCnt <= HOLD_W'(HOLD_LEN);
    end else if (ctl.holdDec && holdCnt != '0) begin
      holdCnt <= holdCnt - HOLD_W'(1);
    end
  end
endmodule

// File: rtl/hdlc_mon_ctl.sv
module hdlc_mon_ctl
  import hdlc_mon_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    bitValid,
  input  logic    winMatch,
  input  logic    holdLast,
  output monCtl_t ctl,
  output logic    flagOn
);
  typedef enum logic {SEARCH, HOLD} flagState_t;

  flagState_t state, stateNext;

  always_comb begin
    stateNext    = state;
    ctl.shiftEn  = bitValid;
    ctl.holdLoad = 1'b0;
    ctl.holdDec  = 1'b0;
    if (bitValid) begin
      unique case (state)
        SEARCH: begin
          if (winMatch) begin
            stateNext    = HOLD;
            ctl.holdLoad = 1'b1;
          end
        end
        HOLD: begin
          if (holdLast) begin
            if (winMatch) ctl.holdLoad = 1'b1;
            else          stateNext    = SEARCH;
          end else begin
            ctl.holdDec = 1'b1;
          end
        end
        default: stateNext = SEARCH;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= SEARCH;
    else       state <= stateNext;
  end

  assign flagOn = (state == HOLD);
endmodule

// File: rtl/hdlc_rx_status_mon.sv
module hdlc_rx_status_mon
  import hdlc_mon_pkg::*;
#(
  parameter int WIN_W    = 8,
  parameter logic [WIN_W-1:0] FLAG_PAT = 8'h7E,
  parameter int IDLE_RUN = 15,
  parameter int HOLD_LEN = 8
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       bitValid,
  input  logic       rxBit,
  input  logic       carrierIn,
  output logic [7:0] statusWord
);
  monCtl_t ctl;
  logic    winMatch;
  logic    holdLast;
  logic    idleNow;
  logic    flagOn;

  hdlc_mon_ctl u_ctl (
    .clk      (clk),
    .rstN     (rstN),
    .bitValid (bitValid),
    .winMatch (winMatch),
    .holdLast (holdLast),
    .ctl      (ctl),
    .flagOn   (flagOn)
  );

  hdlc_mon_dp #(
    .WIN_W    (WIN_W),
    .FLAG_PAT (FLAG_PAT),
    .IDLE_RUN (IDLE_RUN),
    .HOLD_LEN (HOLD_LEN)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .ctl      (ctl),
    .rxBit    (rxBit),
    .winMatch (winMatch),
    .holdLast (holdLast),
    .idleNow  (idleNow)
  );

  assign statusWord = {5'b00000, flagOn, carrierIn, idleNow};
endmodule

// File: rtl/hdlc_rx_status_mon_chk.sv
module hdlc_rx_status_mon_chk #(
  parameter int HOLD_LEN = 8
) (
  input logic       clk,
  input logic       rstN,
  input logic       bitValid,
  input logic       rxBit,
  input logic       carrierIn,
  input logic [7:0] statusWord
);
  localparam int CNT_W = $clog2(HOLD_LEN + 1);

  logic flag, idle;
  logic [CNT_W-1:0] validSinceSet;

  assign flag = statusWord[2];
  assign idle = statusWord[0];

  // valid bits seen since the flag last armed, modulo the hold length
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                validSinceSet <= '0;
    else if (!flag)           validSinceSet <= '0;
    else if (bitValid)        validSinceSet <= (validSinceSet == CNT_W'(HOLD_LEN - 1)) ? '0
                                               : validSinceSet + CNT_W'(1);
  end

  assert_reserved_zero_R9: assert property (@(posedge clk) disable iff (!rstN)
    statusWord[7:3] == 5'b0);

  assert_carrier_follow_R8: assert property (@(posedge clk) disable iff (!rstN)
    statusWord[1] == carrierIn);

  assert_quiet_cycle_R10: assert property (@(posedge clk) disable iff (!rstN)
    !bitValid |=> ($stable(flag) && $stable(idle)));

  assert_idle_clear_R6: assert property (@(posedge clk) disable iff (!rstN)
    (bitValid && !rxBit) |=> !idle);

  assert_flag_rise_R2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(flag) |-> $past(bitValid));

  assert_hold_window_R3: assert property (@(posedge clk) disable iff (!rstN)
    $fell(flag) |-> ($past(bitValid) && $past(validSinceSet) == CNT_W'(HOLD_LEN - 1)));
endmodule

bind hdlc_rx_status_mon hdlc_rx_status_mon_chk #(.HOLD_LEN(HOLD_LEN)) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .bitValid   (bitValid),
  .rxBit      (rxBit),
  .carrierIn  (carrierIn),
  .statusWord (statusWord)
);

// File: tb/hdlc_rx_status_mon_tb.sv
module hdlc_rx_status_mon_tb_top;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rstN;
  logic       bitValid;
  logic       rxBit;
  logic       carrierIn;
  logic [7:0] statusWord;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  // reference state
  logic [7:0] mHist;
  bit         mFlag;
  int         mHold;
  int         mRun;

  always #(CLK_PERIOD/2) clk = ~clk;

  hdlc_rx_status_mon dut_i (
    .clk(clk), .rstN(rstN), .bitValid(bitValid), .rxBit(rxBit),
    .carrierIn(carrierIn), .statusWord(statusWord)
  );

  function automatic bit expIdle();
    return mRun >= 15;
  endfunction

  function automatic logic [7:0] expWord(input logic car);
    return {5'b0, mFlag, car, expIdle()};
  endfunction

  task automatic modelReset();
    mHist = 8'h00; mFlag = 1'b0; mHold = 0; mRun = 0;
  endtask

  task automatic modelStep(input logic b);
    logic [7:0] nw;
    nw = {mHist[6:0], b};
    if (!mFlag) begin
      if (nw == 8'h7E) begin mFlag = 1'b1; mHold = 8; end
    end else begin
      mHold = mHold - 1;
      if (mHold == 0) begin
        if (nw == 8'h7E) mHold = 8;
        else             mFlag = 1'b0;
      end
    end
    mHist = nw;
    if (b) mRun = (mRun < 15) ? mRun + 1 : 15;
    else   mRun = 0;
  endtask

  task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s actual=%02h expected=%02h at %0t", tag, got, exp, $time);
    end
  endtask

  // one cycle: drive at negedge, sample shortly after the following posedge
  task automatic cycle(input logic v, input logic b, input logic car);
    @(negedge clk);
    bitValid = v; rxBit = b; carrierIn = car;
    if (v) modelStep(b);
    @(posedge clk); #2;
  endtask

  task automatic sendByte(input logic [7:0] by, input string tag);
    for (int i = 7; i >= 0; i--) begin
      cycle(1'b1, by[i], 1'b0);
      chk(tag, {5'b0, statusWord[2], 2'b0}, {5'b0, mFlag, 2'b0});
    end
  endtask

  task automatic finish();
    if (!finished) begin
      finished = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish();
  end

  initial begin
    void'($urandom(32'd2024));
    rstN = 1'b0; bitValid = 1'b0; rxBit = 1'b0; carrierIn = 1'b0;
    modelReset();
    repeat (3) @(posedge clk);
    #2;
    chk("R1 reset", statusWord, 8'h00);
    @(negedge clk); rstN = 1'b1;
    @(posedge clk); #2;
    chk("R1 after release", statusWord, 8'h00);

    // R2: flag appears exactly on the eighth bit of 0x7E
    for (int i = 7; i >= 1; i--) cycle(1'b1, 1'(8'h7E >> i), 1'b0);
    chk("R2 not yet set", {5'b0, statusWord[2], 2'b0}, 8'h00);
    cycle(1'b1, 1'b0, 1'b0);
    chk("R2 set on last bit", {5'b0, statusWord[2], 2'b0}, 8'h04);

    // R4: aligned block 0x7E rearms; R3 held through it
    for (int i = 7; i >= 0; i--) begin
      cycle(1'b1, 1'(8'h7E >> i), 1'b0);
      chk("R3 held in window", {5'b0, statusWord[2], 2'b0}, 8'h04);
    end
    chk("R4 rearmed", {5'b0, statusWord[2], 2'b0}, {5'b0, mFlag, 2'b0});

    // R5: block 0x00 clears on its eighth bit, not before
    for (int i = 0; i < 7; i++) begin
      cycle(1'b1, 1'b0, 1'b0);
      chk("R3 held before check", {5'b0, statusWord[2], 2'b0}, 8'h04);
    end
    cycle(1'b1, 1'b0, 1'b0);
    chk("R5 cleared", {5'b0, statusWord[2], 2'b0}, 8'h00);

    // R5: search resumes bit by bit at a new alignment (7 bits after the block)
    for (int i = 0; i < 6; i++) cycle(1'b1, 1'b1, 1'b0);
    cycle(1'b1, 1'b0, 1'b0);
    chk("R5 resumed search", {5'b0, statusWord[2], 2'b0}, 8'h04);
    sendByte(8'h00, "R5 drop again");
    chk("R5 drop again final", {5'b0, statusWord[2], 2'b0}, 8'h00);

    // R6 / R7: idle run
    for (int i = 0; i < 14; i++) cycle(1'b1, 1'b1, 1'b0);
    chk("R6 14 ones not idle", {7'b0, statusWord[0]}, 8'h00);
    cycle(1'b1, 1'b1, 1'b0);
    chk("R6 15 ones idle", {7'b0, statusWord[0]}, 8'h01);
    for (int i = 0; i < 40; i++) cycle(1'b1, 1'b1, 1'b0);
    chk("R7 long run stays idle", {7'b0, statusWord[0]}, 8'h01);

    // R10: invalid cycles with zeros and a full flag pattern change nothing
    for (int i = 7; i >= 0; i--) cycle(1'b0, 1'(8'h7E >> i), 1'b0);
    chk("R10 invalid ignored", statusWord, 8'h01);
    // R8: carrier is combinational
    @(negedge clk); carrierIn = 1'b1; #1;
    chk("R8 carrier high", statusWord, 8'h03);
    carrierIn = 1'b0; #1;
    chk("R8 carrier low", statusWord, 8'h01);
    cycle(1'b1, 1'b0, 1'b0);
    chk("R6 zero clears idle", {7'b0, statusWord[0]}, 8'h00);

    // random stream with injected flags
    for (int n = 0; n < 4000; n++) begin
      logic car;
      car = 1'($urandom % 2);
      if ($urandom % 24 == 0) begin
        logic [7:0] by;
        by = ($urandom % 3 == 0) ? 8'h3F : 8'h7E;
        for (int i = 7; i >= 0; i--) begin
          cycle(1'b1, by[i], car);
          chk("R4 random flag", statusWord, expWord(car));
        end
      end else begin
        logic v, b;
        v = ($urandom % 5) != 0;
        b = ($urandom % 4) != 0;
        cycle(v, b, car);
        chk(v ? "R2 random" : "R10 random", statusWord, expWord(car));
      end
    end
    finish();
  end
endmodule